// File: doc/BRIEF.md
# Palette and Packed Pixel Expander

This block turns a stream of frame-buffer words into a stream of 24-bit RGB pixels, one pixel per accepted output transfer. Each input word carries either one byte (low eight bits of `in_data`) holding one, two or four packed palette indices, or one little-endian halfword holding a direct-colour pixel. Indexed pixels are looked up in a 256 x 16-bit colour table that a sequencer fills through a separate write port. Direct pixels are widened to 24 bits without a table lookup.

The colour depth is not a separate input. It is carried by bits 14:12 of colour-table entry 0 and follows every write to that entry. A panel-type input chooses how 16-bit pixels are read. A per-line pixel counter closes each line after the configured number of pixels, discards the unused bits in the final packed byte, and flags the last pixel. Both streams use a valid/ready handshake.

Top module: `pal_pixel_expander`

## Requirements
- R1: The depth code is bits 14:12 of colour-table entry 0. Code 1 selects 2 bits per pixel, code 2 selects 4, code 3 selects 8, and codes 4 through 7 select 16.
- R2: With depth code 0, input words are accepted (`in_ready` high) and dropped, and no pixel appears on the output.
- R3: In 2-bit and 4-bit modes, the pixels of the byte `in_data[7:0]` leave least significant field first. That gives four pixels per byte at 2 bits and two at 4 bits. In 8-bit mode the whole byte is the index.
- R4: A colour-table entry holds red in bits 11:8, green in 7:4 and blue in 3:0. The output `out_rgb` has red in 23:16, green in 15:8 and blue in 7:0. Each 4-bit component fills the upper nibble of its byte, and the lower nibble is zero.
- R5: At 16 bits per pixel with `cfg_tft` low, `in_data` is direct colour in the same 4:4:4 layout as a table entry and is expanded as in R4.
- R6: At 16 bits per pixel with `cfg_tft` high, `in_data` is 5-6-5: red in 15:11, green in 10:5 and blue in 4:0. Each field sits in the top bits of its output byte, and the bits below it are zero.
- R7: A line has exactly `cfg_width` pixels (`cfg_width` is at least 1). `out_last` is high on the last pixel only. Unused fields of the last packed byte are discarded, and the next line starts with a fresh input word.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rgb` and `out_last` hold their values.
- R9: With `out_ready` held high and input words always available, the block delivers one pixel on every clock cycle.
- R10: After reset, `out_valid` is low, `in_ready` is high and the depth code reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tft | input | 1 | Selects 5-6-5 decoding for 16-bit pixels |
| cfg_width | input | 10 | Pixels per line, at least 1 |
| pal_we | input | 1 | Colour-table write strobe |
| pal_addr | input | 8 | Colour-table write address |
| pal_wdata | input | 16 | Colour-table write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 16 | Byte in bits 7:0, or a 16-bit pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_rgb | output | 24 | Pixel colour, red in the top byte |
| out_last | output | 1 | Last pixel of the line |

## Verification
The bench sends lines whose widths are not a multiple of the pixels per byte, so a design that emitted the leftover fields, or carried them into the next line, would return extra or shifted pixels and move `out_last`. It uses index patterns that differ in every field, so taking fields from the wrong end of the byte shows up as a swapped colour. The 16-bit tests use saturated single-channel values, so misplaced 5-6-5 fields or wrong zero fill appear as wrong byte values. Random output stalls check that a held pixel stays unchanged while the colour table's read register is idle. A run with the output always ready checks that there is no bubble per word, and a depth-0 run checks that input is accepted without any output.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

    typedef enum logic [2:0] {
        BPP_NONE = 3'd0,
        BPP_2    = 3'd1,
        BPP_4    = 3'd2,
        BPP_8    = 3'd3,
        BPP_16   = 3'd4
    } bpp_e;

    typedef enum logic [1:0] {
        KIND_PAL  = 2'd0,
        KIND_D444 = 2'd1,
        KIND_D565 = 2'd2
    } kind_e;

    localparam int CODE_LSB = 12;
    localparam int CODE_W   = 3;

    function automatic bpp_e depth_decode(input logic [CODE_W-1:0] code);
        bpp_e r;
        case (code)
            3'd0:    r = BPP_NONE;
            3'd1:    r = BPP_2;
            3'd2:    r = BPP_4;
            3'd3:    r = BPP_8;
            default: r = BPP_16;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pxe_palette.sv
module pxe_palette
    import pxe_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CODE_W-1:0] depth_code
);

    logic [DATA_W-1:0] mem [ENTRIES];
    logic [DATA_W-1:0] rdata_q;
    logic [CODE_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (wr_en && wr_addr == '0) begin
            code_d = wr_data[CODE_LSB +: CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    // Storage and the registered read port have no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rdata_q <= mem[rd_addr];
        end
    end

    assign rd_data    = rdata_q;
    assign depth_code = code_q;

    // R10: depth code is 0 in the first cycle after reset
    p_code_reset_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> code_q == '0);

endmodule

// File: rtl/pxe_unpack.sv
module pxe_unpack
    import pxe_pkg::*;
#(
    parameter int WIDTH_W = 10,
    parameter int IN_W    = 16,
    parameter int IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bpp_e               bpp,
    input  logic               tft,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_data,
    output logic               in_ready,
    input  logic               out_ready,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_addr,
    output logic               b_valid,
    output kind_e              b_kind,
    output logic [IN_W-1:0]    b_raw,
    output logic               b_last
);

    typedef struct packed {
        logic               a_valid;
        logic [IN_W-1:0]    word;
        logic [1:0]         sub;
        logic [WIDTH_W-1:0] col;
        logic               b_valid;
        kind_e              kind;
        logic [IN_W-1:0]    raw;
        logic               last;
    } st_t;

    st_t d, q;

    logic [1:0]       sub_max;
    logic             sub_last, line_last, word_done;
    logic             mode_ok, b_free, issue, load, in_ready_c;
    logic [IN_W-1:0]  sh;
    logic [IDX_W-1:0] idx;

    always_comb begin
        d = q;

        case (bpp)
            BPP_2:   sub_max = 2'd3;
            BPP_4:   sub_max = 2'd1;
            default: sub_max = 2'd0;
        endcase

        case (bpp)
            BPP_2:   sh = q.word >> {q.sub, 1'b0};
            BPP_4:   sh = q.word >> {q.sub[0], 2'b00};
            default: sh = q.word;
        endcase

        case (bpp)
            BPP_2:   idx = {{(IDX_W-2){1'b0}}, sh[1:0]};
            BPP_4:   idx = {{(IDX_W-4){1'b0}}, sh[3:0]};
            default: idx = sh[IDX_W-1:0];
        endcase

        sub_last   = (q.sub == sub_max);
        line_last  = (q.col == cfg_width - WIDTH_W'(1));
        word_done  = sub_last || line_last;
        mode_ok    = (bpp != BPP_NONE);
        b_free     = !q.b_valid || out_ready;
        issue      = q.a_valid && b_free && mode_ok;
        in_ready_c = !mode_ok || !q.a_valid || (issue && word_done);
        load       = in_valid && in_ready_c && mode_ok;

        if (issue) begin
            d.col = line_last ? '0 : q.col + WIDTH_W'(1);
            d.sub = q.sub + 2'd1;
            if (word_done) begin
                d.a_valid = 1'b0;
            end
        end

        if (load) begin
            d.a_valid = 1'b1;
            d.word    = in_data;
            d.sub     = 2'd0;
        end

        if (b_free) begin
            d.b_valid = issue;
            if (issue) begin
                d.last = line_last;
                d.raw  = q.word;
                if (bpp == BPP_16) begin
                    d.kind = tft ? KIND_D565 : KIND_D444;
                end else begin
                    d.kind = KIND_PAL;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{a_valid: 1'b0, word: '0, sub: '0, col: '0,
                   b_valid: 1'b0, kind: KIND_PAL, raw: '0, last: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign in_ready = in_ready_c;
    assign rd_en    = issue && (bpp != BPP_16);
    assign rd_addr  = idx;
    assign b_valid  = q.b_valid;
    assign b_kind   = q.kind;
    assign b_raw    = q.raw;
    assign b_last   = q.last;

    // R3: the field index never passes the last field of a byte
    p_sub_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.a_valid && mode_ok) |-> q.sub <= sub_max);

    // R7: the pixel that ends a line returns the counter to zero
    p_line_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && line_last) |=> q.col == '0);

    // R2: with depth code 0 no word enters the unpacker
    p_depth0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bpp == BPP_NONE && !q.a_valid) |=> !q.a_valid);

    // R10: the output stage is empty right after reset
    p_out_reset_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> !q.b_valid);

endmodule

// File: rtl/pxe_format.sv
module pxe_format
    import pxe_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int RGB_W = 24
) (
    input  kind_e             kind,
    input  logic [IN_W-1:0]   raw,
    input  logic [IN_W-1:0]   pal_data,
    output logic [RGB_W-1:0]  rgb
);

    logic [IN_W-1:0] src;

    always_comb begin
        src = (kind == KIND_PAL) ? pal_data : raw;
        if (kind == KIND_D565) begin
            rgb = {src[15:11], 3'b000, src[10:5], 2'b00, src[4:0], 3'b000};
        end else begin
            rgb = {src[11:8], 4'h0, src[7:4], 4'h0, src[3:0], 4'h0};
        end
    end

endmodule

// File: rtl/pal_pixel_expander.sv
module pal_pixel_expander
    import pxe_pkg::*;
#(
    parameter int WIDTH_W     = 10,
    parameter int PAL_ENTRIES = 256,
    parameter int IN_W        = 16,
    parameter int RGB_W       = 24,
    localparam int PAL_AW     = $clog2(PAL_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_tft,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               pal_we,
    input  logic [PAL_AW-1:0]  pal_addr,
    input  logic [IN_W-1:0]    pal_wdata,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [IN_W-1:0]    in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [RGB_W-1:0]   out_rgb,
    output logic               out_last
);

    logic [CODE_W-1:0] depth_code;
    bpp_e              bpp;
    logic              rd_en;
    logic [PAL_AW-1:0] rd_addr;
    logic [IN_W-1:0]   rd_data;
    kind_e             b_kind;
    logic [IN_W-1:0]   b_raw;

    assign bpp = depth_decode(depth_code);

    pxe_palette #(
        .ENTRIES (PAL_ENTRIES),
        .DATA_W  (IN_W)
    ) u_palette (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (pal_we),
        .wr_addr    (pal_addr),
        .wr_data    (pal_wdata),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .depth_code (depth_code)
    );

    pxe_unpack #(
        .WIDTH_W (WIDTH_W),
        .IN_W    (IN_W),
        .IDX_W   (PAL_AW)
    ) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bpp       (bpp),
        .tft       (cfg_tft),
        .cfg_width (cfg_width),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .b_valid   (out_valid),
        .b_kind    (b_kind),
        .b_raw     (b_raw),
        .b_last    (out_last)
    );

    pxe_format #(
        .IN_W  (IN_W),
        .RGB_W (RGB_W)
    ) u_format (
        .kind     (b_kind),
        .raw      (b_raw),
        .pal_data (rd_data),
        .rgb      (out_rgb)
    );

    // R8: a stalled pixel is held unchanged
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_rgb) && $stable(out_last)));

    // R8: no colour-table read is issued while the output is stalled
    p_no_read_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !rd_en);

endmodule

// File: tb/pal_pixel_expander_tb_top.sv
module pal_pixel_expander_tb_top;

    localparam int WW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_tft = 1'b0;
    logic [WW-1:0] cfg_width = WW'(1);
    logic          pal_we = 1'b0;
    logic [7:0]    pal_addr = '0;
    logic [15:0]   pal_wdata = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [23:0]   out_rgb;
    logic          out_last;

    always #10 clk = ~clk;

    pal_pixel_expander dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_tft   (cfg_tft),
        .cfg_width (cfg_width),
        .pal_we    (pal_we),
        .pal_addr  (pal_addr),
        .pal_wdata (pal_wdata),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_rgb   (out_rgb),
        .out_last  (out_last)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    int          n_out   = 0;
    longint      cyc     = 0;
    longint      t_first = 0;
    longint      t_last  = 0;
    logic [15:0] mirror [256];
    logic [24:0] exp_q [$];
    string       req_q [$];
    bit          rand_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        hold_chk = 1'b0;
    logic [24:0] hold_val = '0;
    logic [15:0] linebuf [16];
    bit          finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [23:0] x444(input logic [15:0] v);
        return {v[11:8], 4'h0, v[7:4], 4'h0, v[3:0], 4'h0};
    endfunction

    function automatic logic [23:0] x565(input logic [15:0] v);
        return {v[15:11], 3'b000, v[10:5], 2'b00, v[4:0], 3'b000};
    endfunction

    // Monitor and scoreboard
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = rand_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
            #9;
            if (hold_chk) begin
                check(out_valid && ({out_last, out_rgb} == hold_val), "R8",
                      "stalled pixel changed", {7'b0, out_valid, out_last, out_rgb},
                      {8'h01, hold_val[23:0]} | {7'b0, 1'b0, hold_val[24], 24'b0});
            end
            hold_chk = out_valid && !out_ready;
            hold_val = {out_last, out_rgb};
            if (out_valid && out_ready) begin
                n_out++;
                if (n_out == 1) t_first = cyc;
                t_last = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R7", "unexpected pixel", {7'b0, out_last, out_rgb}, 32'h0);
                end else begin
                    logic [24:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check({out_last, out_rgb} == e, r, "pixel {last,rgb}",
                          {7'b0, out_last, out_rgb}, {7'b0, e});
                end
            end
        end
    end

    task automatic push_exp(input logic [23:0] rgb, input bit last, input string r);
        exp_q.push_back({last, rgb});
        req_q.push_back(r);
    endtask

    // Driver: called at a negedge, leaves the bench at a negedge.
    task automatic push_word(input logic [15:0] w);
        bit hs;
        in_valid = 1'b1;
        in_data  = w;
        forever begin
            #9;
            hs = in_ready;
            @(negedge clk);
            if (hs) break;
        end
    endtask

    // bits: 2, 4, 8 or 16; 0 means no output is expected
    task automatic drive_line(input int bits, input int nwords, input string r);
        int col;
        col = 0;
        @(negedge clk);
        for (int w = 0; w < nwords; w++) begin
            if (bits == 16) begin
                if (col < int'(cfg_width)) begin
                    push_exp(cfg_tft ? x565(linebuf[w]) : x444(linebuf[w]),
                             col == int'(cfg_width) - 1, r);
                    col++;
                end
            end else if (bits != 0) begin
                for (int s = 0; s < 8 / bits; s++) begin
                    if (col < int'(cfg_width)) begin
                        logic [7:0] ix;
                        ix = 8'((linebuf[w][7:0] >> (s * bits)) & ((1 << bits) - 1));
                        push_exp(x444(mirror[ix]), col == int'(cfg_width) - 1, r);
                        col++;
                    end
                end
            end
            push_word(linebuf[w]);
        end
        in_valid = 1'b0;
    endtask

    task automatic pal_write(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        pal_we    = 1'b1;
        pal_addr  = a;
        pal_wdata = v;
        mirror[a] = v;
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic set_code(input logic [2:0] c);
        pal_write(8'd0, {1'b0, c, mirror[0][11:0]});
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mirror[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(out_valid == 1'b0, "R10", "out_valid after reset", {31'b0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", {31'b0, in_ready}, 32'h1);

        // Fill the colour table, entry 0 last (code 1 = 2 bpp, R1)
        for (int i = 1; i < 256; i++) begin
            pal_write(8'(i), 16'((i * 16'h0159 + 16'h00A3) & 16'h0FFF) | 16'h8000);
        end
        pal_write(8'd0, 16'h1_5C3);

        // R3 R4 R7: 2 bpp, width 10 (last byte holds 2 leftover fields), two lines
        rand_ready = 1'b1;
        cfg_width  = WW'(10);
        linebuf[0] = 16'h00E4; linebuf[1] = 16'h001B; linebuf[2] = 16'h00C6;
        drive_line(2, 3, "R3");
        linebuf[0] = 16'h0039; linebuf[1] = 16'h0072; linebuf[2] = 16'h00FF;
        drive_line(2, 3, "R7");
        drain();

        // R3 R1: 4 bpp, width 7 (odd), one leftover nibble
        set_code(3'd2);
        cfg_width = WW'(7);
        linebuf[0] = 16'h00A5; linebuf[1] = 16'h003C; linebuf[2] = 16'h0F10;
        linebuf[3] = 16'h0087;
        drive_line(4, 4, "R3");
        drive_line(4, 4, "R7");
        drain();

        // R4 R1: 8 bpp, width 5
        set_code(3'd3);
        cfg_width = WW'(5);
        linebuf[0] = 16'h00FF; linebuf[1] = 16'h1200; linebuf[2] = 16'h0080;
        linebuf[3] = 16'h0001; linebuf[4] = 16'h007E;
        drive_line(8, 5, "R4");
        drain();

        // R5 R1: 16 bpp direct 4:4:4 (code 5, passive panel)
        set_code(3'd5);
        cfg_tft   = 1'b0;
        cfg_width = WW'(4);
        linebuf[0] = 16'hFF00; linebuf[1] = 16'h00F0; linebuf[2] = 16'h000F;
        linebuf[3] = 16'h0A5C;
        drive_line(16, 4, "R5");
        drain();

        // R6 R1: 16 bpp 5-6-5 (code 7, active panel)
        set_code(3'd7);
        cfg_tft = 1'b1;
        linebuf[0] = 16'hF800; linebuf[1] = 16'h07E0; linebuf[2] = 16'h001F;
        linebuf[3] = 16'h8421;
        drive_line(16, 4, "R6");
        drain();
        cfg_tft = 1'b0;

        // R2: depth code 0 accepts and drops input
        set_code(3'd0);
        n_out = 0;
        linebuf[0] = 16'h0011; linebuf[1] = 16'h0022; linebuf[2] = 16'h0033;
        drive_line(0, 3, "R2");
        repeat (10) @(negedge clk);
        check(n_out == 0, "R2", "pixels produced with code 0", n_out, 0);
        check(out_valid == 1'b0, "R2", "out_valid with code 0", {31'b0, out_valid}, 0);

        // R9: 8 bpp, consumer always ready, one pixel per cycle
        set_code(3'd3);
        rand_ready = 1'b0;
        cfg_width  = WW'(16);
        for (int i = 0; i < 16; i++) linebuf[i] = 16'(i * 13 + 7);
        n_out = 0;
        drive_line(8, 16, "R9");
        drain();
        check(n_out == 16, "R9", "pixel count", n_out, 16);
        check(t_last - t_first == 15, "R9", "cycles first to last pixel",
              32'(t_last - t_first), 15);

        check(exp_q.size() == 0, "R7", "pixels still outstanding", exp_q.size(), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule